// File: doc/BRIEF.md
# Serial EEPROM Page Gather and Commit Engine

This block sits behind a two-wire serial front-end and turns a write transaction into one page update of an on-chip byte array. The front-end presents a word address once, then one strobe per incoming data byte. Bytes collect in a sixteen-entry page buffer. Each entry has a received flag. After each byte only the low four bits of the address pointer advance, so the pointer stays inside one page and, once sixteen bytes have arrived, later bytes overwrite earlier ones.

A stop strobe closes the transaction. If at least one byte was received and the transaction was not aborted, a timed internal write cycle begins. For the whole of that cycle `busy_o` is high and every strobe is ignored. On the last clock of the cycle the flagged bytes are written into the array as one atomic update. A transaction with no bytes, or one that the front-end aborted (for example on a write-protect rejection), commits nothing. The pointer keeps its final value for a later access. A combinational tap lets the neighbouring read path observe the array contents.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset `busy_o` is 0, `ptr_o` is 0 and every array byte reads 0xFF on `peek_data_o`.
- R2: An accepted address strobe loads `ptr_o` with the full `addr_i`, clears all received flags and clears any abort state.
- R3: An accepted data byte is stored in page slot `ptr_o[3:0]` and marked received. The low four bits of the pointer then increment modulo 16, and the upper bits do not change.
- R4: When more than 16 bytes arrive in one transaction the pointer wraps within the page, and the later byte replaces the earlier byte in the same slot.
- R5: An accepted stop with at least one received byte and no abort raises `busy_o` on the next clock. `busy_o` then stays high for exactly `WRITE_CYCLES` clocks.
- R6: While `busy_o` is high the array shows its old contents. At the clock edge where `busy_o` falls, each received slot i is written to address {`ptr_o[ADDR_W-1:4]`, i}. All other bytes keep their value.
- R7: A stop with no received byte, or after an abort, starts no cycle. `busy_o` stays 0, the array is unchanged and the received flags are cleared.
- R8: While `busy_o` is high, the address, data, stop and abort strobes have no effect on the pointer, the buffer or the array.
- R9: After a commit, `ptr_o` keeps the value it had when the stop arrived.
- R10: When several strobes are present in one accepted clock, only the one of highest priority acts. The order is abort, then address, then stop, then data.
- R11: An abort discards all received bytes. Data strobes that follow it are ignored until the next address or stop strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_strobe_i | input | 1 | Word address valid; starts a transaction |
| addr_i | input | ADDR_W | Word address |
| data_strobe_i | input | 1 | Data byte valid |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | End of transaction; requests the commit |
| abort_i | input | 1 | Discard the current transaction |
| busy_o | output | 1 | Internal write cycle in progress |
| ptr_o | output | ADDR_W | Current address pointer |
| peek_addr_i | input | ADDR_W | Array tap address |
| peek_data_o | output | 8 | Array byte at `peek_addr_i` (combinational) |

## Verification
The pointer and the buffer register each strobe at the next clock edge. So `ptr_o` shows the result of a strobe one clock after it is sampled, and `busy_o` rises one clock after an accepted stop. The array changes at the edge where `busy_o` falls, which is `WRITE_CYCLES` clocks after it rose. The tap is combinational, so the array value is valid in the same cycle as the tap address. The bench keeps a behavioural model that is advanced at every rising edge from the same sampled inputs. It compares `busy_o`, `ptr_o` and the tapped byte at every falling edge. Those are exactly the points where the edge-registered results are due. The tap address sweeps the whole array so that every location is checked over time.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ABORT,
    OP_ADDR,
    OP_STOP,
    OP_DATA
  } epc_op_e;
endpackage

// File: rtl/epc_pointer.sv
module epc_pointer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LOW_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_addr_i;
    end else if (step_i) begin
      ptr_q[LOW_W-1:0] <= ptr_q[LOW_W-1:0] + LOW_W'(1);
    end
  end

  assign ptr_o = ptr_q;

  // R3
  page_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (ptr_o[ADDR_W-1:LOW_W] == $past(ptr_o[ADDR_W-1:LOW_W])));
  // R4
  low_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && (&ptr_o[LOW_W-1:0])) |=> (ptr_o[LOW_W-1:0] == '0));
endmodule

// File: rtl/epc_page_buf.sv
module epc_page_buf
  import epc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned LOW_W      = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       wr_i,
  input  logic [LOW_W-1:0]           idx_i,
  input  byte_t                      data_i,
  output logic [PAGE_BYTES-1:0][7:0] buf_o,
  output logic [PAGE_BYTES-1:0]      mask_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic  hit;
    byte_t slot_q;
    logic  vld_q;
    assign hit = wr_i && (idx_i == LOW_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
        vld_q  <= 1'b0;
      end else if (clear_i) begin
        vld_q  <= 1'b0;
      end else if (hit) begin
        slot_q <= data_i;
        vld_q  <= 1'b1;
      end
    end

    assign buf_o[g]  = slot_q;
    assign mask_o[g] = vld_q;
  end

  // R3
  slot_written_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i) |=> (buf_o[$past(idx_i)] == $past(data_i)) && mask_o[$past(idx_i)]);
endmodule

// File: rtl/epc_timer.sv
module epc_timer #(
  parameter int unsigned CYCLES = 20,
  localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(CYCLES);
      busy_q <= 1'b1;
    end else if (done_o) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;

  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  // R5
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R5
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/epc_array.sv
module epc_array
  import epc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned LOW_W      = 4,
  localparam int unsigned DEPTH     = 2 ** ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [ADDR_W-LOW_W-1:0]    page_i,
  input  logic [PAGE_BYTES-1:0][7:0] buf_i,
  input  logic [PAGE_BYTES-1:0]      mask_i,
  input  logic [ADDR_W-1:0]          peek_addr_i,
  output byte_t                      peek_data_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask_i[i]) mem_q[{page_i, LOW_W'(i)}] <= buf_i[i];
      end
    end
  end

  assign peek_data_o = mem_q[peek_addr_i];

  // R6
  array_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i ##1 $stable(peek_addr_i)) |-> $stable(peek_data_o));
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
  import epc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PAGE_BYTES   = 16,
  parameter int unsigned WRITE_CYCLES = 20,
  localparam int unsigned LOW_W       = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_strobe_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [7:0]        peek_data_o
);
  epc_op_e                     op;
  logic                        aborted_q;
  logic                        start, done, buf_clear, any_rx;
  logic [PAGE_BYTES-1:0][7:0]  page_buf;
  logic [PAGE_BYTES-1:0]       page_mask;

  always_comb begin
    op = OP_IDLE;
    if (!busy_o) begin
      if (abort_i)                         op = OP_ABORT;
      else if (addr_strobe_i)              op = OP_ADDR;
      else if (stop_i)                     op = OP_STOP;
      else if (data_strobe_i && !aborted_q) op = OP_DATA;
    end
  end

  assign any_rx    = |page_mask;
  assign start     = (op == OP_STOP) && any_rx && !aborted_q;
  assign buf_clear = (op == OP_ABORT) || (op == OP_ADDR) || ((op == OP_STOP) && !start) || done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             aborted_q <= 1'b0;
    else if (op == OP_ABORT)                 aborted_q <= 1'b1;
    else if (op == OP_ADDR || op == OP_STOP) aborted_q <= 1'b0;
  end

  epc_pointer #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_ptr (
    .clk_i, .rst_ni,
    .load_i      (op == OP_ADDR),
    .load_addr_i (addr_i),
    .step_i      (op == OP_DATA),
    .ptr_o       (ptr_o)
  );

  epc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .LOW_W(LOW_W)) u_buf (
    .clk_i, .rst_ni,
    .clear_i (buf_clear),
    .wr_i    (op == OP_DATA),
    .idx_i   (ptr_o[LOW_W-1:0]),
    .data_i  (data_i),
    .buf_o   (page_buf),
    .mask_o  (page_mask)
  );

  epc_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk_i, .rst_ni,
    .start_i (start),
    .busy_o  (busy_o),
    .done_o  (done)
  );

  epc_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .LOW_W(LOW_W)) u_mem (
    .clk_i, .rst_ni,
    .commit_i    (done),
    .page_i      (ptr_o[ADDR_W-1:LOW_W]),
    .buf_i       (page_buf),
    .mask_i      (page_mask),
    .peek_addr_i (peek_addr_i),
    .peek_data_o (peek_data_o)
  );

  // R8
  busy_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ptr_o));
  // R7
  empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && stop_i && !abort_i && !addr_strobe_i && !any_rx) |=> !busy_o);
  // R11
  abort_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && abort_i) |=> (!busy_o && !any_rx));
  // R2
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && addr_strobe_i && !abort_i) |=> (ptr_o == $past(addr_i)) && !any_rx);
endmodule

// File: tb/eeprom_page_commit_tb.sv
module eeprom_page_commit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int WC = 20;
  localparam int DEPTH = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_s = 0, d_s = 0, st = 0, ab = 0;
  logic [AW-1:0] a = '0, peek = '0;
  logic [7:0] d = '0;
  logic busy;
  logic [AW-1:0] ptr;
  logic [7:0] pdata;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_commit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_strobe_i(a_s), .addr_i(a),
    .data_strobe_i(d_s), .data_i(d),
    .stop_i(st), .abort_i(ab),
    .busy_o(busy), .ptr_o(ptr),
    .peek_addr_i(peek), .peek_data_o(pdata)
  );

  // behavioural reference
  bit [7:0] m_mem [DEPTH];
  bit [7:0] m_buf [16];
  bit       m_vld [16];
  bit       m_busy, m_abort;
  int       m_cnt;
  bit [7:0] m_ptr;

  function automatic bit any_vld();
    foreach (m_vld[i]) if (m_vld[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      foreach (m_vld[i]) m_vld[i] = 1'b0;
      m_busy = 0; m_abort = 0; m_cnt = 0; m_ptr = 0;
    end else if (m_busy) begin
      if (m_cnt == 1) begin
        for (int i = 0; i < 16; i++)
          if (m_vld[i]) m_mem[{m_ptr[7:4], 4'(i)}] = m_buf[i];
        foreach (m_vld[i]) m_vld[i] = 1'b0;
        m_busy = 0;
      end else m_cnt--;
    end else if (ab) begin
      m_abort = 1; foreach (m_vld[i]) m_vld[i] = 1'b0;
    end else if (a_s) begin
      m_ptr = a; m_abort = 0; foreach (m_vld[i]) m_vld[i] = 1'b0;
    end else if (st) begin
      if (any_vld() && !m_abort) begin
        m_busy = 1; m_cnt = WC;
      end else foreach (m_vld[i]) m_vld[i] = 1'b0;
      m_abort = 0;
    end else if (d_s && !m_abort) begin
      m_buf[m_ptr[3:0]] = d; m_vld[m_ptr[3:0]] = 1'b1;
      m_ptr[3:0] = m_ptr[3:0] + 4'd1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (busy !== m_busy) begin
        bad++; $display("FAIL %s busy_o actual=%0b expected=%0b", cur_req, busy, m_busy);
      end
      total++;
      if (ptr !== m_ptr) begin
        bad++; $display("FAIL %s ptr_o actual=%02h expected=%02h", cur_req, ptr, m_ptr);
      end
      total++;
      if (pdata !== m_mem[peek]) begin
        bad++; $display("FAIL %s peek[%02h] actual=%02h expected=%02h", cur_req, peek, pdata, m_mem[peek]);
      end
      peek = peek + 8'd1;
    end
  end

  task automatic drive(input bit as_, input bit [7:0] av, input bit ds, input bit [7:0] dv,
                       input bit sv, input bit bv);
    a_s = as_; a = av; d_s = ds; d = dv; st = sv; ab = bv;
    @(negedge clk);
    a_s = 0; d_s = 0; st = 0; ab = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(DEPTH + 2);

    cur_req = "R2"; drive(1, 8'h23, 0, 0, 0, 0);
    cur_req = "R5"; drive(0, 0, 1, 8'hA5, 0, 0); drive(0, 0, 0, 0, 1, 0);
    cur_req = "R6"; settle();

    cur_req = "R3"; drive(1, 8'h4C, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 8'h10 + 8'(i), 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    cur_req = "R8";
    drive(1, 8'hE0, 0, 0, 0, 0); drive(0, 0, 1, 8'h77, 0, 0);
    drive(0, 0, 0, 0, 1, 0); drive(0, 0, 0, 0, 0, 1);
    settle();
    cur_req = "R9"; idle(3);

    cur_req = "R4"; drive(1, 8'h85, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) drive(0, 0, 1, 8'hC0 + 8'(i), 0, 0);
    drive(0, 0, 0, 0, 1, 0); settle();

    cur_req = "R7"; drive(1, 8'h30, 0, 0, 0, 0); drive(0, 0, 0, 0, 1, 0); idle(4);
    cur_req = "R11"; drive(1, 8'h31, 0, 0, 0, 0); drive(0, 0, 1, 8'h5A, 0, 0);
    drive(0, 0, 0, 0, 0, 1); drive(0, 0, 1, 8'h6B, 0, 0);
    cur_req = "R7"; drive(0, 0, 0, 0, 1, 0); idle(4);

    cur_req = "R10";
    drive(1, 8'hB2, 1, 8'h99, 0, 0);
    drive(0, 0, 1, 8'h3C, 0, 0);
    drive(1, 8'hD0, 0, 0, 0, 1);
    drive(1, 8'hB7, 0, 0, 0, 0);
    drive(0, 0, 1, 8'h42, 0, 0);
    drive(0, 0, 1, 8'h43, 1, 0);
    settle();
    drive(1, 8'hF0, 1, 8'h01, 1, 1); idle(3);

    cur_req = "R6"; idle(DEPTH + 2);
    report();
  end
endmodule